// File: doc/BRIEF.md
# Comparator-Terminated Half-Bridge Gate Sequencer

This block drives the two gates of a resonant half-bridge whose switching period is not fixed. Each high-side conduction interval ends when a sampled resonant-capacitor voltage reaches a threshold. That threshold comes from an internal ramp. At every high-side turn-on the ramp loads the control word from the outer voltage loop. It then falls by a programmable step each clock, which gives slope compensation when the voltage swing is small.

The block counts the high-side conduction time in clock cycles and replays that same count on the low side. The low gate is therefore derived from the high gate rather than from a free-running timer. Three settings shape the high-side interval:

- a programmable dead time, inserted on both edges of every switch;
- a leading-edge blanking window, during which trips are ignored;
- minimum and maximum on-time clamps, which bound the interval.

Voltage samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` is held high, and a beat is consumed on every cycle in which `smp_valid` is high. A beat that is not valid can never end a high phase. The configuration inputs are plain levels. The control word is captured only at high-side turn-on.

Top module: `hb_trip_pwm`

## Requirements
- R1: While `en` is low, `gate_hi` and `gate_lo` are both low in the same cycle, and the sequencer returns to idle. Once `en` rises, `gate_hi` first rises after a dead-time gap.
- R2: A high phase ends on a valid sample whose value is at or above the ramp threshold, provided blanking and the minimum on-time are satisfied. The cycle carrying the trip is the last cycle of `gate_hi`.
- R3: In high-phase cycle k (k=0 at turn-on), the threshold equals `ctrl_word - k*slope_step`, floored at 0. Every high phase restarts from `ctrl_word`.
- R4: A trip in high-phase cycle k is ignored while k < `blank_cyc`.
- R5: The high on-time is never shorter than `ton_min` cycles. A trip that arrives earlier ends the phase at `ton_min`.
- R6: The high on-time never exceeds `ton_max` cycles. Without a trip, the phase ends after exactly `ton_max` cycles.
- R7: Every high-to-low and low-to-high transition passes through a gap of max(`dead_cyc`,1) cycles in which both gates are low.
- R8: The low phase lasts exactly as many cycles as the high phase just before it.
- R9: A change to `ctrl_word` during a high phase does not affect that phase. It takes effect at the next high-side turn-on.
- R10: `smp_ready` is always high. A sample with `smp_valid` low never ends a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable, active high |
| ctrl_word | input | DATA_W | Ramp start value from the voltage loop |
| slope_step | input | DATA_W | Ramp decrement per high-phase cycle |
| dead_cyc | input | DEAD_W | Dead time in cycles (0 behaves as 1) |
| blank_cyc | input | TIME_W | Blanking window length after high turn-on |
| ton_min | input | TIME_W | Minimum high on-time |
| ton_max | input | TIME_W | Maximum high on-time |
| smp_data | input | DATA_W | Sampled capacitor voltage, unsigned |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Sample beat accepted (always high) |
| gate_hi | output | 1 | High-side gate |
| gate_lo | output | 1 | Low-side gate |

## Verification
The gate outputs are decoded from the phase register and gated by `en`. A change of `en` therefore shows on the gates in the same cycle, while every other stimulus shows up one clock edge later.

After `en` rises, the first dead-time cycle is visible after the next rising edge. A trip in high cycle k makes the gap start at the edge that follows, so the measured width is k+1. The ramp value for cycle k is loaded by the edge that opens the phase.

The bench drives inputs and samples outputs on falling edges. It measures each gate interval by counting falling-edge samples of a constant output level. Expected widths are therefore whole-cycle counts computed from the requirement formulas.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DEADH = 3'd1,
    PH_HIGH  = 3'd2,
    PH_DEADL = 3'd3,
    PH_LOW   = 3'd4
  } phase_e;
endpackage

// File: rtl/hbpwm_ramp.sv
module hbpwm_ramp #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] slope_step,
  output logic [DATA_W-1:0] thr
);
  logic [DATA_W-1:0] thr_q;
  logic [DATA_W-1:0] thr_dec;

  // floor at zero instead of wrapping
  assign thr_dec = (thr_q > slope_step) ? (thr_q - slope_step) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     thr_q <= '0;
    else if (load)  thr_q <= ctrl_word;
    else if (run)   thr_q <= thr_dec;
  end

  assign thr = thr_q;

  assert_load_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> thr_q == $past(ctrl_word));

  assert_ramp_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> thr_q <= $past(thr_q));
endmodule

// File: rtl/hbpwm_trip.sv
module hbpwm_trip #(
  parameter int DATA_W = 12,
  parameter int TIME_W = 10
) (
  input  logic              in_high,
  input  logic [TIME_W-1:0] cnt,
  input  logic [TIME_W-1:0] blank_cyc,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] thr,
  output logic              trip
);
  logic crossed;
  logic unblanked;

  assign crossed   = smp_valid && (smp_data >= thr);
  assign unblanked = (cnt >= blank_cyc);
  assign trip      = in_high && crossed && unblanked;
endmodule

// File: rtl/hbpwm_seq.sv
module hbpwm_seq
  import hbpwm_pkg::*;
#(
  parameter int TIME_W = 10,
  parameter int DEAD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              trip,
  input  logic [DEAD_W-1:0] dead_cyc,
  input  logic [TIME_W-1:0] ton_min,
  input  logic [TIME_W-1:0] ton_max,
  output phase_e            phase,
  output logic [TIME_W-1:0] cnt,
  output logic              load,
  output logic              run
);
  phase_e            ph_q, ph_n;
  logic [TIME_W-1:0] cnt_q, cnt_inc, ton_lat;
  logic              tripped;
  logic              dead_done, hi_end, lo_end;

  // saturating increment: elapsed cycles including the current one
  assign cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign dead_done = (cnt_inc >= TIME_W'(dead_cyc));
  assign hi_end    = (((tripped || trip) && (cnt_inc >= ton_min)) ||
                      (cnt_inc >= ton_max));
  assign lo_end    = (cnt_inc >= ton_lat);

  always_comb begin
    ph_n = ph_q;
    case (ph_q)
      PH_IDLE:  ph_n = PH_DEADH;
      PH_DEADH: if (dead_done) ph_n = PH_HIGH;
      PH_HIGH:  if (hi_end)    ph_n = PH_DEADL;
      PH_DEADL: if (dead_done) ph_n = PH_LOW;
      PH_LOW:   if (lo_end)    ph_n = PH_DEADH;
      default:  ph_n = PH_IDLE;
    endcase
    if (!en) ph_n = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      ton_lat <= TIME_W'(1);
      tripped <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      cnt_q   <= (ph_n != ph_q) ? '0 : cnt_inc;
      if (ph_q == PH_HIGH && ph_n != PH_HIGH) ton_lat <= cnt_inc;
      tripped <= (ph_q == PH_HIGH && ph_n == PH_HIGH) ? (tripped || trip) : 1'b0;
    end
  end

  assign phase = ph_q;
  assign cnt   = cnt_q;
  assign load  = (ph_q != PH_HIGH) && (ph_n == PH_HIGH);
  assign run   = (ph_q == PH_HIGH);

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ph_q == PH_IDLE);

  assert_max_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HIGH && cnt_inc >= ton_max) |=> ph_q != PH_HIGH);

  assert_gap_after_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_HIGH && $past(ph_q) == PH_HIGH) |-> (ph_q == PH_DEADL || ph_q == PH_IDLE));

  assert_gap_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_LOW && $past(ph_q) == PH_LOW) |-> (ph_q == PH_DEADH || ph_q == PH_IDLE));

  assert_low_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LOW) |-> cnt_q < ton_lat);
endmodule

// File: rtl/hb_trip_pwm.sv
module hb_trip_pwm
  import hbpwm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int TIME_W = 10,
  parameter int DEAD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] slope_step,
  input  logic [DEAD_W-1:0] dead_cyc,
  input  logic [TIME_W-1:0] blank_cyc,
  input  logic [TIME_W-1:0] ton_min,
  input  logic [TIME_W-1:0] ton_max,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_valid,
  output logic              smp_ready,
  output logic              gate_hi,
  output logic              gate_lo
);
  phase_e            phase;
  logic [TIME_W-1:0] cnt;
  logic [DATA_W-1:0] thr;
  logic              load, run, trip;

  hbpwm_seq #(.TIME_W(TIME_W), .DEAD_W(DEAD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .trip(trip),
    .dead_cyc(dead_cyc), .ton_min(ton_min), .ton_max(ton_max),
    .phase(phase), .cnt(cnt), .load(load), .run(run)
  );

  hbpwm_ramp #(.DATA_W(DATA_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run),
    .ctrl_word(ctrl_word), .slope_step(slope_step), .thr(thr)
  );

  hbpwm_trip #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_trip (
    .in_high(run), .cnt(cnt), .blank_cyc(blank_cyc),
    .smp_data(smp_data), .smp_valid(smp_valid), .thr(thr), .trip(trip)
  );

  assign smp_ready = 1'b1;
  assign gate_hi   = en && (phase == PH_HIGH);
  assign gate_lo   = en && (phase == PH_LOW);

  assert_off_gates_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (phase == PH_IDLE));

  assert_invalid_no_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !smp_valid && cnt + 1'b1 < ton_max && cnt < {TIME_W{1'b1}}) |=> phase == PH_HIGH);
endmodule

// File: tb/sim_hb_trip_pwm.sv
`timescale 1ns/1ps
module sim_hb_trip_pwm;
  localparam int DW = 12, TW = 10, EW = 6;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [DW-1:0] ctrl_word = '0, slope_step = '0, smp_data = '0;
  logic [EW-1:0] dead_cyc = '0;
  logic [TW-1:0] blank_cyc = '0, ton_min = '0, ton_max = '0;
  logic smp_valid = 1'b0;
  logic smp_ready, gate_hi, gate_lo;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hb_trip_pwm #(.DATA_W(DW), .TIME_W(TW), .DEAD_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ctrl_word(ctrl_word),
    .slope_step(slope_step), .dead_cyc(dead_cyc), .blank_cyc(blank_cyc),
    .ton_min(ton_min), .ton_max(ton_max), .smp_data(smp_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .gate_hi(gate_hi), .gate_lo(gate_lo));

  // columns: ctrl, step, level, blank, tmin, tmax, dead, expected high on-time
  localparam int NV = 6;
  localparam int VEC [0:NV-1][0:7] = '{
    '{1000, 10, 900, 2,  3, 200, 3, 11},  // R2 trip at k=10
    '{ 500, 60,   0, 0,  1, 200, 2, 10},  // R3 ramp floors at 0 in k=9
    '{ 100,  0, 200, 7,  1, 200, 1,  8},  // R4 blanked until k=7
    '{ 100,  0, 200, 0, 12, 200, 4, 12},  // R5 early trip held to min
    '{4000,  1,   0, 0,  1,  25, 2, 25},  // R6 no trip, max reached
    '{ 300, 20, 100, 0,  1, 200, 0, 11}   // R7 zero dead behaves as one
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3: return "R5"; 4: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind 0: both low, 1: only high gate, 2: only low gate
  task automatic run_len(input int kind, output int n);
    n = 0;
    for (int g = 0; g < 3000; g++) begin
      if (kind == 0 && (gate_hi || gate_lo)) break;
      if (kind == 1 && !(gate_hi && !gate_lo)) break;
      if (kind == 2 && !(gate_lo && !gate_hi)) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic disable_run();
    en = 1'b0;
    #1;
    check("R1 gates low when disabled", int'(gate_hi) + int'(gate_lo), 0);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    int d1, th, d2, tl, d3, th2, dx;
    @(negedge clk);
    check("R1 reset gate_hi", int'(gate_hi), 0);
    check("R1 reset gate_lo", int'(gate_lo), 0);
    check("R10 ready high", int'(smp_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ctrl_word  = DW'(VEC[i][0]); slope_step = DW'(VEC[i][1]);
      smp_data   = DW'(VEC[i][2]); blank_cyc  = TW'(VEC[i][3]);
      ton_min    = TW'(VEC[i][4]); ton_max    = TW'(VEC[i][5]);
      dead_cyc   = EW'(VEC[i][6]); smp_valid  = 1'b1;
      dx = (VEC[i][6] < 1) ? 1 : VEC[i][6];
      en = 1'b1;
      @(negedge clk);
      run_len(0, d1); run_len(1, th); run_len(0, d2);
      run_len(2, tl); run_len(0, d3); run_len(1, th2);
      check("R7 dead before first high", d1, dx);
      check({tag_of(i), " high on-time"}, th, VEC[i][7]);
      check("R7 dead high to low", d2, dx);
      check("R8 low on-time equals high", tl, VEC[i][7]);
      check("R7 dead low to high", d3, dx);
      check("R3 ramp restarts each high phase", th2, VEC[i][7]);
      disable_run();
    end

    // R9: control word changed inside a high phase
    ctrl_word = 12'd1000; slope_step = 12'd10; smp_data = 12'd900;
    blank_cyc = '0; ton_min = 10'd1; ton_max = 10'd200; dead_cyc = 6'd2;
    smp_valid = 1'b1; en = 1'b1;
    @(negedge clk);
    run_len(0, d1);
    ctrl_word = 12'd2000;
    run_len(1, th); run_len(0, d2); run_len(2, tl); run_len(0, d3); run_len(1, th2);
    check("R9 change ignored in current phase", th, 11);
    check("R9 new word used at next turn-on", th2, 111);
    disable_run();

    // R10: invalid samples never trip, phase runs to max
    ctrl_word = 12'd10; slope_step = 12'd0; smp_data = 12'd4000;
    ton_max = 10'd30; smp_valid = 1'b0; en = 1'b1;
    @(negedge clk);
    run_len(0, d1); run_len(1, th);
    check("R10 invalid beats ignored", th, 30);
    disable_run();

    // R1: disable in the middle of a high phase, then restart
    smp_valid = 1'b1; ton_max = 10'd200; slope_step = 12'd0;
    ctrl_word = 12'd4000; smp_data = 12'd0; dead_cyc = 6'd5;
    en = 1'b1;
    @(negedge clk);
    run_len(0, d1);
    @(negedge clk); @(negedge clk);
    check("R1 high active before disable", int'(gate_hi), 1);
    disable_run();
    check("R1 still low after idle", int'(gate_hi) + int'(gate_lo), 0);
    en = 1'b1;
    @(negedge clk);
    run_len(0, d1);
    check("R1 restart begins with dead time", d1, 5);
    check("R1 high rises after restart", int'(gate_hi), 1);
    en = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule